// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbitration Selector

This block looks at a small set of transmit message buffers and picks the one that should go on the bus next. Each buffer presents a 29-bit identifier field, a format flag (standard or extended), a remote-request flag, a 4-bit length code, a 3-bit local priority and a ready flag. For every ready buffer the block builds a ranking key, finds the smallest key and registers the winner's index together with a valid flag, the winner's length code and the number of payload bytes the frame carries.

The ranking follows the dominant-low rule of the bus. Only the 11 base identifier bits count for a standard buffer. An extended buffer uses all 29 bits. A standard buffer wins over an extended one with the same base bits. When a global enable is set, the 3-bit local priority, which is never transmitted, ranks above the identifier. The selection is recomputed in every cycle, and the result appears on the registered outputs one clock later.

Top module: `can_tx_arbiter`

## Requirements
- R1: `win_valid` is 1 in the cycle after a clock edge at which at least one bit of `mb_ready` was 1, and 0 after an edge at which no bit was set.
- R2: When `win_valid` is 1, `win_index` names a buffer whose ready bit was 1 at the capturing edge.
- R3: The winner has the smallest ranking key among the ready buffers. The key orders first by local priority (only when enabled), then by the base identifier bits `mb_id[28:18]`, then by format (standard before extended), then by the low bits `mb_id[17:0]` (extended only). A smaller value wins.
- R4: When two ready buffers have equal keys, the one with the lower index wins.
- R5: For a standard buffer (`mb_ide`=0), identifier bits 17..0 have no effect on selection.
- R6: An extended buffer (`mb_ide`=1) ranks by all 29 bits, and a standard buffer beats an extended buffer that has the same bits 28..18.
- R7: With `lprio_en`=0, the local priority field has no effect on selection.
- R8: With `lprio_en`=1, a buffer with a smaller local priority wins over any buffer with a larger one, whatever their identifiers.
- R9: `win_dlc` equals the length code of the winning buffer, unchanged.
- R10: `win_bytes` is 0 when the winner has `mb_rtr`=1. Otherwise it is the length code, clamped to 8 for codes 9 to 15.
- R11: While `rst_n` is 0 at a clock edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lprio_en | input | 1 | Global enable for local priority in the ranking |
| mb_ready | input | NUM_MB | Per-buffer ready flag |
| mb_ide | input | NUM_MB | Per-buffer format: 1 extended, 0 standard |
| mb_rtr | input | NUM_MB | Per-buffer remote-request flag |
| mb_id | input | NUM_MB*29 | Identifier fields, buffer i in bits [29*i+28 : 29*i] |
| mb_prio | input | NUM_MB*3 | Local priorities, buffer i in bits [3*i+2 : 3*i] |
| mb_dlc | input | NUM_MB*4 | Length codes, buffer i in bits [4*i+3 : 4*i] |
| win_valid | output | 1 | A winner exists |
| win_index | output | $clog2(NUM_MB) | Index of the winning buffer |
| win_dlc | output | 4 | Length code of the winner |
| win_bytes | output | 4 | Payload bytes of the winner (0 to 8) |

## Verification
The result passes through one register, so a fault in the key builder or the minimum search shows at the ports on the next edge as a wrong `win_index`. The faults include a misplaced format bit, a priority that ignores its enable, and a comparison that does not break ties in the required order. A fault in the byte mapping shows as a wrong `win_bytes` in that same cycle. The random frames draw identifiers from a small pool so that equal base bits and full ties occur often. Directed cases cover the format ordering, the priority enable, remote frames and length clamping, so each ordering rule decides at least one selection on its own.

// File: rtl/can_arb_pkg.sv
// Package: sizes shared by the arbitration selector and its submodules.
// Assumes an identifier field of 29 bits, of which the top 11 form the base.
package can_arb_pkg;
    localparam int ID_W   = 29;
    localparam int BASE_W = 11;
    localparam int LOW_W  = ID_W - BASE_W;
    localparam int PRIO_W = 3;
    localparam int DLC_W  = 4;
    localparam int KEY_W  = PRIO_W + BASE_W + 1 + LOW_W;
    localparam int MAX_BYTES = 8;
endpackage

// File: rtl/can_arb_keygen.sv
// Module: builds the ranking key of one transmit buffer.
// Key layout from MSB: local priority (zero when disabled), base identifier
// bits, format bit (standard = 0 ranks first), low identifier bits (zero for
// standard frames). A smaller key wins. Purely combinational.
module can_arb_keygen
    import can_arb_pkg::*;
(
    input  logic              en_prio,
    input  logic [ID_W-1:0]   id,
    input  logic              ide,
    input  logic [PRIO_W-1:0] prio,
    output logic [KEY_W-1:0]  key
);
    // Assemble the key fields in ranking order.
    always_comb begin
        key = {en_prio ? prio : {PRIO_W{1'b0}},
               id[ID_W-1 -: BASE_W],
               ide,
               ide ? id[LOW_W-1:0] : {LOW_W{1'b0}}};
    end
endmodule

// File: rtl/can_arb_minsel.sv
// Module: finds the smallest key among the flagged candidates.
// Scans from index 0 upward with a strict comparison, so on equal keys the
// lower index is kept. Purely combinational.
module can_arb_minsel
    import can_arb_pkg::*;
#(
    parameter int N     = 8,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]        cand,
    input  logic [KEY_W-1:0]    keys [N],
    output logic                any,
    output logic [IW-1:0]       idx,
    output logic [KEY_W-1:0]    best
);
    // Linear scan keeping the first strictly smaller key.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!any || keys[i] < best)) begin
                any  = 1'b1;
                idx  = IW'(i);
                best = keys[i];
            end
        end
    end
endmodule

// File: rtl/can_arb_lenmap.sv
// Module: turns a length code into a payload byte count.
// Remote frames carry no payload; codes above the maximum are clamped.
module can_arb_lenmap
    import can_arb_pkg::*;
(
    input  logic [DLC_W-1:0] dlc,
    input  logic             rtr,
    output logic [DLC_W-1:0] bytes
);
    // Map code to byte count with clamp and remote override.
    always_comb begin
        if (rtr)
            bytes = '0;
        else if (dlc > DLC_W'(MAX_BYTES))
            bytes = DLC_W'(MAX_BYTES);
        else
            bytes = dlc;
    end
endmodule

// File: rtl/can_tx_arbiter.sv
// Module: transmit mailbox arbitration selector (top).
// Builds a key per buffer, searches the minimum over ready buffers and
// registers winner index, valid, length code and byte count one cycle later.
// Assumes NUM_MB >= 2. Synchronous active-low reset clears all outputs.
module can_tx_arbiter
    import can_arb_pkg::*;
#(
    parameter int NUM_MB = 8,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lprio_en,
    input  logic [NUM_MB-1:0]         mb_ready,
    input  logic [NUM_MB-1:0]         mb_ide,
    input  logic [NUM_MB-1:0]         mb_rtr,
    input  logic [NUM_MB*ID_W-1:0]    mb_id,
    input  logic [NUM_MB*PRIO_W-1:0]  mb_prio,
    input  logic [NUM_MB*DLC_W-1:0]   mb_dlc,
    output logic                      win_valid,
    output logic [IDX_W-1:0]          win_index,
    output logic [DLC_W-1:0]          win_dlc,
    output logic [DLC_W-1:0]          win_bytes
);
    logic [KEY_W-1:0] keys [NUM_MB];
    logic             sel_any;
    logic [IDX_W-1:0] sel_idx;
    logic [KEY_W-1:0] sel_key;
    logic [DLC_W-1:0] sel_dlc;
    logic             sel_rtr;
    logic [DLC_W-1:0] sel_bytes;
    logic [KEY_W-1:0] win_key_q;

    // One key builder per buffer.
    for (genvar g = 0; g < NUM_MB; g++) begin : g_key
        can_arb_keygen u_key (
            .en_prio (lprio_en),
            .id      (mb_id[g*ID_W +: ID_W]),
            .ide     (mb_ide[g]),
            .prio    (mb_prio[g*PRIO_W +: PRIO_W]),
            .key     (keys[g])
        );
    end

    can_arb_minsel #(.N(NUM_MB)) u_min (
        .cand (mb_ready),
        .keys (keys),
        .any  (sel_any),
        .idx  (sel_idx),
        .best (sel_key)
    );

    // Pick the winner's length code and remote flag.
    always_comb begin
        sel_dlc = mb_dlc[sel_idx*DLC_W +: DLC_W];
        sel_rtr = mb_rtr[sel_idx];
    end

    can_arb_lenmap u_len (
        .dlc   (sel_dlc),
        .rtr   (sel_rtr),
        .bytes (sel_bytes)
    );

    // Register the selection result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_index <= '0;
            win_dlc   <= '0;
            win_bytes <= '0;
            win_key_q <= '0;
        end else begin
            win_valid <= sel_any;
            win_index <= sel_any ? sel_idx : '0;
            win_dlc   <= sel_any ? sel_dlc : '0;
            win_bytes <= sel_any ? sel_bytes : '0;
            win_key_q <= sel_key;
        end
    end

    p_valid_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (win_valid == (|$past(mb_ready))));

    p_winner_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && win_valid) |-> (($past(mb_ready) >> win_index) & 1) != 0);

    p_no_payload_rtr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && win_valid && ((($past(mb_rtr) >> win_index) & 1) != 0))
        |-> (win_bytes == '0));

    p_byte_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_bytes <= DLC_W'(MAX_BYTES));

    // Every ready key is no smaller than the winner; earlier ones strictly larger.
    for (genvar j = 0; j < NUM_MB; j++) begin : g_chk
        p_lowest_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && win_valid && $past(mb_ready[j]))
            |-> ($past(keys[j]) >= win_key_q));
        p_tie_low_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && win_valid && $past(mb_ready[j]) && (j < int'(win_index)))
            |-> ($past(keys[j]) > win_key_q));
    end
endmodule

// File: tb/can_tx_arbiter_tb.sv
`timescale 1ns/1ps
module can_tx_arbiter_tb;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [N-1:0] rdy = '0, ide = '0, rtr = '0;
    logic [28:0] id [N];
    logic [2:0]  pr [N];
    logic [3:0]  dl [N];
    logic [N*29-1:0] id_f;
    logic [N*3-1:0]  pr_f;
    logic [N*4-1:0]  dl_f;
    logic       w_valid;
    logic [2:0] w_index;
    logic [3:0] w_dlc, w_bytes;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            id_f[i*29 +: 29] = id[i];
            pr_f[i*3 +: 3]   = pr[i];
            dl_f[i*4 +: 4]   = dl[i];
        end
    end

    can_tx_arbiter #(.NUM_MB(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .lprio_en(en), .mb_ready(rdy),
        .mb_ide(ide), .mb_rtr(rtr), .mb_id(id_f), .mb_prio(pr_f),
        .mb_dlc(dl_f), .win_valid(w_valid), .win_index(w_index),
        .win_dlc(w_dlc), .win_bytes(w_bytes)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // True when buffer a ranks strictly ahead of buffer b.
    function automatic bit beats(int a, int b);
        if (en && pr[a] != pr[b]) return pr[a] < pr[b];
        if (id[a][28:18] != id[b][28:18]) return id[a][28:18] < id[b][28:18];
        if (ide[a] != ide[b]) return !ide[a];
        if (ide[a] && id[a][17:0] != id[b][17:0]) return id[a][17:0] < id[b][17:0];
        return 1'b0;
    endfunction

    function automatic int pick();
        int best = -1;
        for (int i = 0; i < N; i++)
            if (rdy[i] && (best < 0 || beats(i, best))) best = i;
        return best;
    endfunction

    function automatic int nbytes(int i);
        if (rtr[i]) return 0;
        return (dl[i] > 8) ? 8 : int'(dl[i]);
    endfunction

    // Wait one edge, then compare all outputs against the model.
    task automatic step_check(string tag);
        int w;
        w = pick();
        @(negedge clk);
        chk({tag, " R1 valid"}, int'(w_valid), (w >= 0) ? 1 : 0);
        if (w >= 0) begin
            chk({tag, " R2/R3 index"}, int'(w_index), w);
            chk({tag, " R9 dlc"}, int'(w_dlc), int'(dl[w]));
            chk({tag, " R10 bytes"}, int'(w_bytes), nbytes(w));
        end
    endtask

    task automatic clear_all();
        rdy = '0; ide = '0; rtr = '0; en = 1'b0;
        for (int i = 0; i < N; i++) begin
            id[i] = 29'h1FFF_FFFF; pr[i] = 3'd7; dl[i] = 4'd0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_all();
        rdy = '1; dl[0] = 4'd5;
        repeat (3) @(negedge clk);
        // R11 outputs zero during reset
        chk("R11 valid", int'(w_valid), 0);
        chk("R11 index", int'(w_index), 0);
        chk("R11 dlc", int'(w_dlc), 0);
        chk("R11 bytes", int'(w_bytes), 0);
        rst_n = 1'b1;
        clear_all();
        step_check("none ready");

        // R5: standard low bits ignored, tie resolved by index (R4)
        clear_all();
        rdy[2] = 1; rdy[5] = 1;
        id[2] = {11'h123, 18'h3FFFF}; id[5] = {11'h123, 18'h00001};
        step_check("R5 std low bits");
        chk("R5 winner", int'(w_index), 2);

        // R6: standard beats extended with same base
        clear_all();
        rdy[1] = 1; rdy[6] = 1; ide[1] = 1;
        id[1] = {11'h0AA, 18'h0}; id[6] = {11'h0AA, 18'h3FFFF};
        step_check("R6 std vs ext");
        chk("R6 std wins", int'(w_index), 6);

        // R6: extended compares low bits
        clear_all();
        rdy[0] = 1; rdy[3] = 1; ide[0] = 1; ide[3] = 1;
        id[0] = {11'h055, 18'h00100}; id[3] = {11'h055, 18'h000FF};
        step_check("R6 ext low");
        chk("R6 ext low wins", int'(w_index), 3);

        // R7 / R8: priority enable
        clear_all();
        rdy[3] = 1; rdy[4] = 1;
        id[3] = {11'h001, 18'h0}; pr[3] = 3'd7;
        id[4] = {11'h7FF, 18'h0}; pr[4] = 3'd0;
        step_check("R7 prio off");
        chk("R7 id decides", int'(w_index), 3);
        en = 1'b1;
        step_check("R8 prio on");
        chk("R8 prio decides", int'(w_index), 4);

        // R4: all identical, index 0 wins
        clear_all();
        rdy = '1;
        step_check("R4 full tie");
        chk("R4 index0", int'(w_index), 0);

        // R9 / R10: clamp, remote, exact eight
        clear_all();
        rdy[7] = 1; dl[7] = 4'd12;
        step_check("R10 clamp");
        chk("R10 clamp bytes", int'(w_bytes), 8);
        chk("R9 raw dlc", int'(w_dlc), 12);
        rtr[7] = 1; dl[7] = 4'd5;
        step_check("R10 remote");
        chk("R10 remote bytes", int'(w_bytes), 0);
        rtr[7] = 0; dl[7] = 4'd8;
        step_check("R10 eight");

        // Constrained random with small identifier pools to force ties
        for (int it = 0; it < 400; it++) begin
            en  = 1'($urandom_range(0, 1));
            rdy = N'($urandom);
            ide = N'($urandom);
            rtr = N'($urandom);
            for (int i = 0; i < N; i++) begin
                id[i] = {11'($urandom_range(0, 3)), 18'($urandom_range(0, 3))};
                pr[i] = 3'($urandom_range(0, 2));
                dl[i] = 4'($urandom);
            end
            step_check("R3 random");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule